// File: doc/BRIEF.md
# Valley-count switch-on controller

This block decides when the primary switch of a quasi-resonant flyback converter turns on and off. After each turn-off the drain rings. The block counts the zero crossings of that ringing, which arrive as single-cycle detect pulses. It turns the gate on at a chosen valley. The valley number follows the load: a slowly clocked up/down counter raises it when the feedback flags show light load and lowers it when they show heavy load. A hysteresis band between two feedback thresholds keeps the chosen valley from jittering.

Several timing limits bound each switching cycle:
- A ringing-suppression window keeps the gate low right after turn-off. The window is short or long depending on the auxiliary-voltage flag.
- A maximum off time forces the gate on when too few crossings arrive.
- A maximum on time forces the gate off.
- A blanking window after turn-on hides the current-sense off-request, which sets the minimum on time.

All inputs are comparator flags that are already synchronous to the block clock. Every duration is a parameter counted in clock cycles.

Top module: `valley_switch_ctrl`

## Requirements
- R1: The valley target changes only at the last cycle of a tick window of TICK_CYC clock cycles, or on a forced reset to 1 (R3). At that cycle the flags of the whole window, including that cycle, are judged. With no low-threshold flag in the window the target steps up. With a low-threshold flag but no high-threshold flag it holds. With a high-threshold flag it steps down. The result is visible one cycle later, and the flags are forgotten for the next window.
- R2: The valley target always lies between 1 and 7. A step above 7 or below 1 leaves it unchanged.
- R3: A cycle with the reset-threshold flag or the start-up clear input high sets the target to 1 on the next cycle, whatever the tick. Start-up clear also forgets the flags gathered in the current window.
- R4: The zero-crossing count increments by one for each cycle with a detect pulse while the gate is low, saturates at 7, and reads 0 in the first cycle the gate is high. Pulses while the gate is high are not counted.
- R5: After each gate fall the gate stays low for at least RS_SHORT cycles. In any low cycle where the auxiliary flag is low, the gate may only rise once it has been low for at least RS_LONG cycles.
- R6: Once suppression has ended, the gate rises on the next cycle when the zero-crossing count is greater than or equal to the valley target.
- R7: A gate that has been low for OFF_MAX cycles rises, regardless of the counts and the auxiliary flag.
- R8: A gate that has been high for ON_MAX cycles falls.
- R9: The current-sense off-request is ignored during the first LEB_CYC−1 high cycles. A request in any later high cycle makes the gate fall on the next cycle, so the gate is never high for fewer than LEB_CYC cycles.
- R10: In reset the gate is low, the target is 1 and the zero-crossing count is 0. The first low period starts at reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_over_lo | input | 1 | Feedback above the lower hysteresis threshold |
| fb_over_hi | input | 1 | Feedback above the upper hysteresis threshold |
| fb_over_rst | input | 1 | Feedback above the fast-reset threshold |
| startup_clr | input | 1 | Start-up clear of the valley target |
| zc_det | input | 1 | One-cycle pulse per detected falling zero crossing |
| aux_over_rs | input | 1 | Auxiliary voltage above the suppression-select level |
| cs_off_req | input | 1 | Turn-off request from the current-sense comparator |
| gate_on | output | 1 | Gate drive command |
| valley_target | output | 3 | Current valley target (1..7) |
| zc_count | output | 3 | Zero crossings counted in the present off period |

## Verification
The hardest situation to reach is a valley turn-on at a high target. That needs the target already stepped up to 7 over several slow ticks, then enough crossings counted while the gate is low, with the suppression window and the off-time limit competing for the same cycle. The bench shortens the tick window through a parameter. It holds the feedback flags low for many windows to climb the target, then feeds crossing pulses at several densities with the auxiliary flag varied. This covers saturation of the crossing count, turn-on exactly at the end of suppression, and forced turn-on at maximum off time. A behavioural model tracks the expected gate, target and count on every cycle.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int VALLEY_MAX = 7;
    localparam int VALLEY_W   = $clog2(VALLEY_MAX + 1);

    typedef logic [VALLEY_W-1:0] valley_t;

    typedef enum logic {
        GATE_LOW  = 1'b0,
        GATE_HIGH = 1'b1
    } gate_e;

    typedef struct packed {
        logic    seen_lo;
        logic    seen_hi;
        valley_t target;
    } tgt_state_t;
endpackage

// File: rtl/vsc_tick_gen.sv
module vsc_tick_gen #(
    parameter int TICK_CYC = 2_400_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TKW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [TKW-1:0] LAST = TKW'(TICK_CYC - 1);

    logic [TKW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/vsc_valley_target.sv
module vsc_valley_target
    import vsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    fb_over_lo,
    input  logic    fb_over_hi,
    input  logic    fb_over_rst,
    input  logic    startup_clr,
    output valley_t target
);
    localparam valley_t V_ONE = valley_t'(1);
    localparam valley_t V_TOP = valley_t'(VALLEY_MAX);

    tgt_state_t st_d, st_q;
    logic lo_any, hi_any;

    always_comb begin
        st_d   = st_q;
        lo_any = st_q.seen_lo | fb_over_lo;
        hi_any = st_q.seen_hi | fb_over_hi;
        st_d.seen_lo = lo_any;
        st_d.seen_hi = hi_any;
        if (tick) begin
            st_d.seen_lo = 1'b0;
            st_d.seen_hi = 1'b0;
            if (!lo_any) begin
                if (st_q.target != V_TOP) st_d.target = st_q.target + V_ONE;
            end else if (hi_any) begin
                if (st_q.target != V_ONE) st_d.target = st_q.target - V_ONE;
            end
        end
        if (fb_over_rst || startup_clr) st_d.target = V_ONE;
        if (startup_clr) begin
            st_d.seen_lo = 1'b0;
            st_d.seen_hi = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seen_lo: 1'b0, seen_hi: 1'b0, target: V_ONE};
        else        st_q <= st_d;
    end

    assign target = st_q.target;

    assert_target_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.target >= V_ONE) && (st_q.target <= V_TOP));
    assert_fast_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_over_rst || startup_clr) |=> (st_q.target == V_ONE));
    assert_only_at_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !fb_over_rst && !startup_clr) |=> $stable(st_q.target));
endmodule

// File: rtl/vsc_gate_timer.sv
module vsc_gate_timer
    import vsc_pkg::*;
#(
    parameter int RS_SHORT = 125,
    parameter int RS_LONG  = 1250,
    parameter int OFF_MAX  = 2100,
    parameter int ON_MAX   = 1500,
    parameter int LEB_CYC  = 17
) (
    input  logic    clk,
    input  logic    rst_n,
    input  valley_t target,
    input  logic    zc_det,
    input  logic    aux_over_rs,
    input  logic    cs_off_req,
    output logic    gate_on,
    output valley_t zc_count
);
    localparam int SPAN = (OFF_MAX > ON_MAX) ? OFF_MAX : ON_MAX;
    localparam int TW   = $clog2(SPAN) + 1;
    localparam logic [TW-1:0] RSS_LIM = TW'(RS_SHORT - 1);
    localparam logic [TW-1:0] RSL_LIM = TW'(RS_LONG - 1);
    localparam logic [TW-1:0] OFF_LIM = TW'(OFF_MAX - 1);
    localparam logic [TW-1:0] ON_LIM  = TW'(ON_MAX - 1);
    localparam logic [TW-1:0] LEB_LIM = TW'(LEB_CYC - 1);
    localparam valley_t V_TOP = valley_t'(VALLEY_MAX);

    typedef struct packed {
        gate_e          st;
        logic [TW-1:0]  tmr;
        valley_t        zc;
    } gt_state_t;

    gt_state_t g_d, g_q;
    logic rs_done;

    always_comb begin
        g_d     = g_q;
        rs_done = aux_over_rs ? (g_q.tmr >= RSS_LIM) : (g_q.tmr >= RSL_LIM);
        unique case (g_q.st)
            GATE_LOW: begin
                if ((rs_done && (g_q.zc >= target)) || (g_q.tmr == OFF_LIM)) begin
                    g_d.st  = GATE_HIGH;
                    g_d.tmr = '0;
                    g_d.zc  = '0;
                end else begin
                    g_d.tmr = g_q.tmr + 1'b1;
                    if (zc_det && (g_q.zc != V_TOP)) g_d.zc = g_q.zc + 1'b1;
                end
            end
            GATE_HIGH: begin
                if ((cs_off_req && (g_q.tmr >= LEB_LIM)) || (g_q.tmr == ON_LIM)) begin
                    g_d.st  = GATE_LOW;
                    g_d.tmr = '0;
                end else begin
                    g_d.tmr = g_q.tmr + 1'b1;
                end
            end
            default: g_d = g_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{st: GATE_LOW, tmr: '0, zc: '0};
        else        g_q <= g_d;
    end

    assign gate_on  = (g_q.st == GATE_HIGH);
    assign zc_count = g_q.zc;

    assert_zc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> (zc_count == '0));
    assert_zc_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && $past(gate_on)) |-> $stable(zc_count));
    assert_min_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> ($past(g_q.tmr) >= RSS_LIM));
    assert_off_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |-> (g_q.tmr <= OFF_LIM));
    assert_on_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> (g_q.tmr <= ON_LIM));
    assert_min_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_on) |-> ($past(g_q.tmr) >= LEB_LIM));
endmodule

// File: rtl/valley_switch_ctrl.sv
module valley_switch_ctrl
    import vsc_pkg::*;
#(
    parameter int TICK_CYC = 2_400_000,
    parameter int RS_SHORT = 125,
    parameter int RS_LONG  = 1250,
    parameter int OFF_MAX  = 2100,
    parameter int ON_MAX   = 1500,
    parameter int LEB_CYC  = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_over_lo,
    input  logic       fb_over_hi,
    input  logic       fb_over_rst,
    input  logic       startup_clr,
    input  logic       zc_det,
    input  logic       aux_over_rs,
    input  logic       cs_off_req,
    output logic       gate_on,
    output logic [2:0] valley_target,
    output logic [2:0] zc_count
);
    logic    tick;
    valley_t tgt;
    valley_t zc;

    vsc_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vsc_valley_target u_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .fb_over_lo  (fb_over_lo),
        .fb_over_hi  (fb_over_hi),
        .fb_over_rst (fb_over_rst),
        .startup_clr (startup_clr),
        .target      (tgt)
    );

    vsc_gate_timer #(
        .RS_SHORT (RS_SHORT),
        .RS_LONG  (RS_LONG),
        .OFF_MAX  (OFF_MAX),
        .ON_MAX   (ON_MAX),
        .LEB_CYC  (LEB_CYC)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .target      (tgt),
        .zc_det      (zc_det),
        .aux_over_rs (aux_over_rs),
        .cs_off_req  (cs_off_req),
        .gate_on     (gate_on),
        .zc_count    (zc)
    );

    assign valley_target = tgt;
    assign zc_count      = zc;

    assert_valley_turn_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) && ($past(zc) < $past(tgt)) |-> ($past(u_gate.g_q.tmr) == u_gate.OFF_LIM));
endmodule

// File: tb/tb_valley_switch_ctrl.sv
module tb_valley_switch_ctrl;
    localparam int TICK = 40;
    localparam int RSS  = 6;
    localparam int RSL  = 20;
    localparam int OFFM = 30;
    localparam int ONM  = 12;
    localparam int LEB  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_lo = 1'b0, fb_hi = 1'b0, fb_rst = 1'b0, st_clr = 1'b0;
    logic zc = 1'b0, aux = 1'b0, cs = 1'b0;
    logic gate;
    logic [2:0] tgt, zcc;

    always #10 clk = ~clk;

    valley_switch_ctrl #(
        .TICK_CYC (TICK), .RS_SHORT (RSS), .RS_LONG (RSL),
        .OFF_MAX  (OFFM), .ON_MAX (ONM), .LEB_CYC (LEB)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .fb_over_lo (fb_lo), .fb_over_hi (fb_hi), .fb_over_rst (fb_rst),
        .startup_clr (st_clr), .zc_det (zc), .aux_over_rs (aux),
        .cs_off_req (cs), .gate_on (gate), .valley_target (tgt), .zc_count (zcc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_gate, m_tgt, m_zc, m_time, m_tick, n_tgt, rs_len;
    bit m_slo, m_shi, lo_any, hi_any, tick_now;
    string gate_tag = "R10";
    string tgt_tag  = "R10";

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gate = 0; m_tgt = 1; m_zc = 0; m_time = 0; m_tick = 0;
            m_slo = 0; m_shi = 0;
        end else begin
            tick_now = (m_tick == TICK - 1);
            m_tick   = tick_now ? 0 : m_tick + 1;
            lo_any   = m_slo | fb_lo;
            hi_any   = m_shi | fb_hi;
            n_tgt    = m_tgt;
            tgt_tag  = "R1";
            if (tick_now) begin
                if (!lo_any) begin
                    if (m_tgt < 7) n_tgt = m_tgt + 1; else tgt_tag = "R2";
                end else if (hi_any) begin
                    if (m_tgt > 1) n_tgt = m_tgt - 1; else tgt_tag = "R2";
                end
                m_slo = 0; m_shi = 0;
            end else begin
                m_slo = lo_any; m_shi = hi_any;
            end
            if (fb_rst || st_clr) begin n_tgt = 1; tgt_tag = "R3"; end
            if (st_clr) begin m_slo = 0; m_shi = 0; end

            if (m_gate == 1) begin
                if (cs && m_time >= LEB - 1) begin
                    m_gate = 0; m_time = 0; gate_tag = "R9";
                end else if (m_time == ONM - 1) begin
                    m_gate = 0; m_time = 0; gate_tag = "R8";
                end else begin
                    m_time++; gate_tag = "R9";
                end
            end else begin
                rs_len = aux ? RSS : RSL;
                if (m_time >= rs_len - 1 && m_zc >= m_tgt) begin
                    m_gate = 1; m_time = 0; m_zc = 0; gate_tag = "R6";
                end else if (m_time == OFFM - 1) begin
                    m_gate = 1; m_time = 0; m_zc = 0; gate_tag = "R7";
                end else begin
                    gate_tag = (m_time < rs_len - 1) ? "R5" : "R6";
                    m_time++;
                    if (zc && m_zc < 7) m_zc++;
                end
            end
            m_tgt = n_tgt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(gate_tag, "gate_on", int'(gate), m_gate);
            chk(tgt_tag, "valley_target", int'(tgt), m_tgt);
            chk("R4", "zc_count", int'(zcc), m_zc);
        end
    end

    task automatic phase(int cyc, int lo_pct, int hi_pct, int zc_pct, int aux_pct, int cs_pct);
        repeat (cyc) begin
            @(negedge clk);
            fb_lo  = ($urandom_range(0, 99) < lo_pct);
            fb_hi  = fb_lo && ($urandom_range(0, 99) < hi_pct);
            fb_rst = 1'b0;
            st_clr = 1'b0;
            zc     = ($urandom_range(0, 99) < zc_pct);
            aux    = ($urandom_range(0, 99) < aux_pct);
            cs     = ($urandom_range(0, 99) < cs_pct);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "gate_on in reset", int'(gate), 0);
        chk("R10", "target in reset", int'(tgt), 1);
        chk("R10", "zc_count in reset", int'(zcc), 0);
        rst_n = 1'b1;

        // R1/R2: light load climbs the target to its ceiling
        phase(TICK * 9, 0, 0, 30, 50, 20);
        @(negedge clk);
        chk("R2", "target at ceiling", int'(tgt), 7);
        // R1: hysteresis band holds
        phase(TICK * 4, 50, 0, 40, 50, 20);
        @(negedge clk);
        chk("R1", "target held in band", int'(tgt), 7);
        // R1/R2: heavy load walks down to the floor
        phase(TICK * 9, 70, 60, 40, 50, 20);
        @(negedge clk);
        chk("R2", "target at floor", int'(tgt), 1);
        // R3: reset-threshold pulse
        phase(TICK * 3, 0, 0, 40, 50, 20);
        @(negedge clk);
        fb_rst = 1'b1;
        @(negedge clk);
        fb_rst = 1'b0;
        chk("R3", "target after fast reset", int'(tgt), 1);
        // R3: start-up clear
        phase(TICK * 3, 0, 0, 40, 50, 20);
        @(negedge clk);
        st_clr = 1'b1;
        @(negedge clk);
        st_clr = 1'b0;
        chk("R3", "target after start-up clear", int'(tgt), 1);
        // R7/R8: high target, no crossings, no current-sense request
        phase(TICK * 7, 0, 0, 0, 0, 0);
        // R4/R5: dense crossings with long suppression
        phase(TICK * 3, 0, 0, 100, 0, 0);
        // R9: request always present
        phase(TICK * 3, 0, 0, 50, 100, 100);
        // mixed patterns
        phase(TICK * 12, 30, 20, 60, 50, 30);
        phase(TICK * 6, 10, 0, 25, 80, 10);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule